// File: doc/BRIEF.md
# Per-Block Read Disturb Tracker

Repeated page reads slowly shift the charge on erased cells that share an erase block with the page being read. Past a certain number of reads, the block's contents must be copied elsewhere and the block erased. This tracker counts reads for every erase block of a NAND array and tells the flash management layer which blocks need that treatment. It consumes a stream of commands. Each command names one block and marks itself as a page read, a block erase, or both.

Every accepted read adds one to that block's counter. The counters sit in an on-chip memory with one read port and one write port, indexed by block, and are updated by read-modify-write over two pipeline stages. The read that brings a counter to the active limit places the block's index in a small relocation queue. The limit is one value for single-level cells and another for multi-level cells, chosen by a mode input. A counter at the limit stays there. An erase returns the counter to zero and withdraws any queued request for that block. The queue presents block indices over a valid/ready handshake. Moving the data is the consumer's job.

Top module: `rd_disturb_tracker`

## Requirements
- R1: After reset the tracker writes zero to every counter, one block per cycle, and holds `cmdReady` low for those `NUM_BLOCKS` cycles. `relocValid` stays low.
- R2: Counts are kept per block. Reads of one block never move the count of another, and a block with fewer reads than the limit raises no request.
- R3: An erase (`cmdErase`=1) sets that block's count to zero and withdraws its queued request. The request disappears from `relocValid` by the cycle after the erase leaves the pipeline. Counting restarts from zero, and a withdrawn entry's slot frees when it reaches the head of the queue.
- R4: The limit is `SLC_LIMIT` when `mlcMode`=0 and `MLC_LIMIT` when `mlcMode`=1. The mode is sampled in the cycle after the command is accepted.
- R5: The read that brings a block's count to the limit queues that block's index. When the queue was empty, the index shows on `relocBlock` with `relocValid`=1 two clock edges after the read is accepted.
- R6: Counters saturate at the limit and never wrap. Any read of a block at the limit queues the block again if it is not currently queued.
- R7: A block index is never present twice in the relocation queue.
- R8: A command with both `cmdRead`=1 and `cmdErase`=1 acts as an erase only, and the block counts from zero afterwards.
- R9: A command naming the same block as the command accepted on the previous cycle waits exactly one cycle, with `cmdReady` low. A command naming a different block is not held.
- R10: Requests leave the queue in the order they were queued. While `relocValid`=1 and `relocReady`=0, `relocBlock` holds steady unless that block is erased.
- R11: When all `QUEUE_DEPTH` slots are occupied, a new request is dropped rather than queued. A later read of that saturated block queues it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| mlcMode | input | 1 | 0: single-level limit, 1: multi-level limit |
| cmdValid | input | 1 | Command present |
| cmdRead | input | 1 | Command is a page read |
| cmdErase | input | 1 | Command is a block erase (wins over read) |
| cmdBlock | input | clog2(NUM_BLOCKS) | Block addressed by the command |
| cmdReady | output | 1 | Command accepted on this edge when high with cmdValid |
| relocValid | output | 1 | A relocation request is offered |
| relocBlock | output | clog2(NUM_BLOCKS) | Block that must be relocated and erased |
| relocReady | input | 1 | Consumer takes the offered request |

## Verification
The assertions assume three things about the inputs. `cmdBlock` addresses an existing block. `mlcMode` does not change while a command is between acceptance and its write-back. `relocReady` is a plain level that the consumer may drop at any time. The stimulus meets these by changing the mode only after the queue has drained and the pipeline is idle, and by using block indices inside the configured array. A reference model of counters and queue predicts every index that reaches the consumer. The stimulus holds `relocReady` low while commands flow, so queue contents never depend on a race between consumer and erase.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  // strobes from the control stage to the counter datapath
  typedef struct packed {
    logic initWr;      // clearing sweep after reset is active
    logic stageLive;   // write-back stage holds a command
    logic stageErase;  // that command is an erase
    logic ramRd;       // fetch the counter of the incoming block
  } rdtStrobe_t;
endpackage

// File: rtl/rdt_ctrl.sv
module rdt_ctrl
  import rdt_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdRead,
  input  logic             cmdErase,
  input  logic [BLK_W-1:0] cmdBlock,
  output logic             cmdReady,
  output rdtStrobe_t       strobe,
  output logic [BLK_W-1:0] initAddr,
  output logic [BLK_W-1:0] stageBlock
);
  logic             initDone;
  logic [BLK_W-1:0] initCnt;
  logic             s1Valid;
  logic             s1Erase;
  logic [BLK_W-1:0] s1Block;
  logic             hazard;
  logic             accept;

  assign hazard   = s1Valid && (cmdBlock == s1Block);
  assign cmdReady = initDone && !hazard;
  assign accept   = cmdValid && cmdReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      initDone <= 1'b0;
      initCnt  <= '0;
      s1Valid  <= 1'b0;
      s1Erase  <= 1'b0;
      s1Block  <= '0;
    end else begin
      if (!initDone) begin
        if (initCnt == BLK_W'(NUM_BLOCKS - 1)) initDone <= 1'b1;
        else                                   initCnt  <= initCnt + 1'b1;
      end
      s1Valid <= accept && (cmdRead || cmdErase);
      if (accept) begin
        s1Erase <= cmdErase;
        s1Block <= cmdBlock;
      end
    end
  end

  always_comb begin
    strobe.initWr     = !initDone;
    strobe.stageLive  = s1Valid;
    strobe.stageErase = s1Erase;
    strobe.ramRd      = accept && cmdRead && !cmdErase;
  end
  assign initAddr   = initCnt;
  assign stageBlock = s1Block;

  // R9: a repeat of the block just accepted must wait one cycle
  p_repeat_stall_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cmdValid && cmdReady && (cmdRead || cmdErase)) && cmdValid &&
     cmdBlock == $past(cmdBlock)) |-> !cmdReady);

  // R1: no command enters before the clearing sweep has covered every block
  p_sweep_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initDone) |-> initCnt == BLK_W'(NUM_BLOCKS - 1));
endmodule

// File: rtl/rdt_datapath.sv
module rdt_datapath
  import rdt_pkg::*;
#(
  parameter int NUM_BLOCKS = 2048,
  parameter int CNT_W      = 20,
  parameter int SLC_LIMIT  = 1000000,
  parameter int MLC_LIMIT  = 100000,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rdtStrobe_t       strobe,
  input  logic             mlcMode,
  input  logic [BLK_W-1:0] rdAddr,
  input  logic [BLK_W-1:0] initAddr,
  input  logic [BLK_W-1:0] stageBlock,
  output logic             pushReq,
  output logic             eraseHit
);
  logic [CNT_W-1:0] countMem [NUM_BLOCKS];
  logic [CNT_W-1:0] rdData;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] bumped;
  logic [CNT_W-1:0] wrData;
  logic [BLK_W-1:0] wrAddr;
  logic             wrEn;

  always_ff @(posedge clk) begin
    if (wrEn)         countMem[wrAddr] <= wrData;
    if (strobe.ramRd) rdData <= countMem[rdAddr];
  end

  assign limit  = mlcMode ? CNT_W'(MLC_LIMIT) : CNT_W'(SLC_LIMIT);
  assign bumped = (rdData >= limit) ? rdData : rdData + 1'b1;

  always_comb begin
    wrEn   = strobe.initWr || strobe.stageLive;
    wrAddr = strobe.initWr ? initAddr : stageBlock;
    if (strobe.initWr || strobe.stageErase) wrData = '0;
    else                                    wrData = bumped;
  end

  assign pushReq  = strobe.stageLive && !strobe.stageErase && (bumped >= limit);
  assign eraseHit = strobe.stageLive && strobe.stageErase;

  // R6: a read never makes a counter smaller (no wrap)
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stageLive && !strobe.stageErase && !strobe.initWr) |-> wrData >= rdData);
endmodule

// File: rtl/rdt_relocq.sv
module rdt_relocq #(
  parameter int DEPTH = 4,
  parameter int BLK_W = 11,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushReq,
  input  logic [BLK_W-1:0] pushBlock,
  input  logic             eraseHit,
  input  logic [BLK_W-1:0] eraseBlock,
  input  logic             relocReady,
  output logic             relocValid,
  output logic [BLK_W-1:0] relocBlock
);
  logic [BLK_W-1:0] entBlk  [DEPTH];
  logic             entLive [DEPTH];
  logic [DEPTH-1:0] dupHit;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [PTR_W:0]   fill;
  logic             full;
  logic             nonEmpty;
  logic             headLive;
  logic             doPush;
  logic             doPop;

  assign full       = (fill == (PTR_W + 1)'(DEPTH));
  assign nonEmpty   = (fill != '0);
  assign doPush     = pushReq && !(|dupHit) && !full;
  assign headLive   = entLive[rdPtr];
  assign relocValid = nonEmpty && headLive;
  assign relocBlock = entBlk[rdPtr];
  assign doPop      = nonEmpty && (!headLive || relocReady);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign dupHit[g] = entLive[g] && (entBlk[g] == pushBlock);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entLive[g] <= 1'b0;
        entBlk[g]  <= '0;
      end else if (doPush && wrPtr == PTR_W'(g)) begin
        entLive[g] <= 1'b1;
        entBlk[g]  <= pushBlock;
      end else if ((doPop && rdPtr == PTR_W'(g)) ||
                   (eraseHit && entBlk[g] == eraseBlock)) begin
        entLive[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  // R7: two live slots never carry the same block
  for (genvar a = 0; a < DEPTH; a++) begin : g_pa
    for (genvar b = a + 1; b < DEPTH; b++) begin : g_pb
      p_unique_r7: assert property (@(posedge clk) disable iff (!rstN)
        !(entLive[a] && entLive[b] && entBlk[a] == entBlk[b]));
    end
  end

  // R10: an offered request waits unchanged for the consumer
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rstN)
    (relocValid && !relocReady && !(eraseHit && eraseBlock == relocBlock))
      |=> (relocValid && $stable(relocBlock)));

  // R3: an erased block is not offered on the following cycle
  p_erase_withdraw_r3: assert property (@(posedge clk) disable iff (!rstN)
    eraseHit |=> !(relocValid && relocBlock == $past(eraseBlock)));

  // R11: occupancy stays within the queue
  p_fill_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    fill <= (PTR_W + 1)'(DEPTH));
endmodule

// File: rtl/rd_disturb_tracker.sv
module rd_disturb_tracker
  import rdt_pkg::*;
#(
  parameter int NUM_BLOCKS  = 2048,
  parameter int SLC_LIMIT   = 1000000,
  parameter int MLC_LIMIT   = 100000,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          mlcMode,
  input  logic                          cmdValid,
  input  logic                          cmdRead,
  input  logic                          cmdErase,
  input  logic [$clog2(NUM_BLOCKS)-1:0] cmdBlock,
  output logic                          cmdReady,
  output logic                          relocValid,
  output logic [$clog2(NUM_BLOCKS)-1:0] relocBlock,
  input  logic                          relocReady
);
  localparam int BLK_W   = $clog2(NUM_BLOCKS);
  localparam int MAX_LIM = (SLC_LIMIT > MLC_LIMIT) ? SLC_LIMIT : MLC_LIMIT;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  rdtStrobe_t       strobe;
  logic [BLK_W-1:0] initAddr;
  logic [BLK_W-1:0] stageBlock;
  logic             pushReq;
  logic             eraseHit;

  rdt_ctrl #(.NUM_BLOCKS(NUM_BLOCKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdErase(cmdErase), .cmdBlock(cmdBlock), .cmdReady(cmdReady),
    .strobe(strobe), .initAddr(initAddr), .stageBlock(stageBlock)
  );

  rdt_datapath #(
    .NUM_BLOCKS(NUM_BLOCKS), .CNT_W(CNT_W),
    .SLC_LIMIT(SLC_LIMIT), .MLC_LIMIT(MLC_LIMIT)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .mlcMode(mlcMode),
    .rdAddr(cmdBlock), .initAddr(initAddr), .stageBlock(stageBlock),
    .pushReq(pushReq), .eraseHit(eraseHit)
  );

  rdt_relocq #(.DEPTH(QUEUE_DEPTH), .BLK_W(BLK_W)) i_relocq (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .pushBlock(stageBlock),
    .eraseHit(eraseHit), .eraseBlock(stageBlock), .relocReady(relocReady),
    .relocValid(relocValid), .relocBlock(relocBlock)
  );
endmodule

// File: tb/test_rd_disturb_tracker.sv
module test_rd_disturb_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 16;
  localparam int SLC = 10;
  localparam int MLC = 4;
  localparam int QD  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mlcMode = 1'b0;
  logic       cmdValid = 1'b0;
  logic       cmdRead = 1'b0;
  logic       cmdErase = 1'b0;
  logic [3:0] cmdBlock = '0;
  logic       cmdReady;
  logic       relocValid;
  logic [3:0] relocBlock;
  logic       relocReady = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  int cnt [NB];
  int expQ [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  rd_disturb_tracker #(
    .NUM_BLOCKS(NB), .SLC_LIMIT(SLC), .MLC_LIMIT(MLC), .QUEUE_DEPTH(QD)
  ) i_rd_disturb_tracker (
    .clk(clk), .rstN(rstN), .mlcMode(mlcMode), .cmdValid(cmdValid),
    .cmdRead(cmdRead), .cmdErase(cmdErase), .cmdBlock(cmdBlock),
    .cmdReady(cmdReady), .relocValid(relocValid), .relocBlock(relocBlock),
    .relocReady(relocReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inQ(input int b);
    foreach (expQ[i]) if (expQ[i] == b) return 1'b1;
    return 1'b0;
  endfunction

  // driver: issue one command, update the reference model
  task automatic issue(input bit rd, input bit er, input int blk, output int stalls);
    int lim;
    cmdValid = 1'b1; cmdRead = rd; cmdErase = er; cmdBlock = 4'(blk);
    stalls = 0;
    while (1) begin
      #1;
      if (cmdReady) begin
        @(negedge clk);
        break;
      end
      stalls++;
      @(negedge clk);
    end
    cmdValid = 1'b0; cmdRead = 1'b0; cmdErase = 1'b0;
    lim = mlcMode ? MLC : SLC;
    if (er) begin
      cnt[blk] = 0;
      for (int i = expQ.size() - 1; i >= 0; i--) if (expQ[i] == blk) expQ.delete(i);
    end else if (rd) begin
      if (cnt[blk] < lim) cnt[blk]++;
      if (cnt[blk] >= lim && !inQ(blk) && expQ.size() < QD) expQ.push_back(blk);
    end
  endtask

  task automatic reads(input int blk, input int n);
    int s;
    for (int i = 0; i < n; i++) issue(1'b1, 1'b0, blk, s);
  endtask

  task automatic drain(input string req);
    relocReady = 1'b1;
    repeat (10) @(negedge clk);
    relocReady = 1'b0;
    #1;
    chk(expQ.size() == 0, req, expQ.size(), 0);
    chk(relocValid == 1'b0, req, relocValid, 0);
  endtask

  // monitor: compare every delivered request with the model's queue
  always @(negedge clk) begin
    if (rstN && relocValid && relocReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10 unexpected request", relocBlock, -1);
      end else begin
        int e;
        e = expQ.pop_front();
        chk(relocBlock == 4'(e), "R10 delivered block", relocBlock, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int s;
    foreach (cnt[i]) cnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(cmdReady == 1'b0, "R1 ready low at sweep start", cmdReady, 0);
    chk(relocValid == 1'b0, "R1 no request after reset", relocValid, 0);
    repeat (5) @(negedge clk);
    #1;
    chk(cmdReady == 1'b0, "R1 ready low mid sweep", cmdReady, 0);
    repeat (15) @(negedge clk);
    #1;
    chk(cmdReady == 1'b1, "R1 ready after sweep", cmdReady, 1);
    @(negedge clk);

    // R2 / R5: single-level limit, per-block counting
    reads(3, 9);
    reads(4, 9);
    repeat (2) @(negedge clk);
    chk(relocValid == 1'b0, "R2 below limit", relocValid, 0);
    reads(3, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd3, "R5 request at limit", relocBlock, 3);
    repeat (3) @(negedge clk);
    chk(relocValid && relocBlock == 4'd3, "R10 held while not ready", relocBlock, 3);
    reads(4, 1);
    drain("R5 drain order");

    // R9: repeat of the same block stalls exactly once
    issue(1'b1, 1'b0, 5, s);
    issue(1'b1, 1'b0, 5, s);
    chk(s == 1, "R9 same block stall", s, 1);
    issue(1'b1, 1'b0, 6, s);
    chk(s == 0, "R9 other block no stall", s, 0);

    // R8: read and erase together act as erase
    reads(7, 3);
    issue(1'b1, 1'b1, 7, s);
    reads(7, 9);
    repeat (2) @(negedge clk);
    chk(relocValid == 1'b0, "R8 counting restarted", relocValid, 0);
    reads(7, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd7, "R8 request after full count", relocBlock, 7);
    drain("R8 drain");

    // R4: multi-level limit
    mlcMode = 1'b1;
    reads(2, 3);
    repeat (2) @(negedge clk);
    chk(relocValid == 1'b0, "R4 below mlc limit", relocValid, 0);
    reads(2, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd2, "R4 request at mlc limit", relocBlock, 2);
    drain("R4 drain");

    // R6 / R7: saturation, requeue, no duplicates, no wrap
    reads(2, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd2, "R6 requeue saturated", relocBlock, 2);
    reads(2, 11);
    drain("R7 single entry");
    reads(2, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd2, "R6 no wrap", relocBlock, 2);
    drain("R6 drain");

    // R3: erase withdraws request and clears the count
    reads(9, 4);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd9, "R3 queued before erase", relocBlock, 9);
    issue(1'b0, 1'b1, 9, s);
    @(negedge clk);
    chk(relocValid == 1'b0, "R3 request withdrawn", relocValid, 0);
    reads(9, 3);
    repeat (2) @(negedge clk);
    chk(relocValid == 1'b0, "R3 count cleared", relocValid, 0);
    reads(9, 1);
    drain("R3 drain");

    // R11: full queue drops, later read requeues
    reads(10, 4);
    reads(11, 4);
    reads(12, 4);
    reads(13, 4);
    reads(14, 4);
    drain("R11 drain full");
    reads(14, 1);
    @(negedge clk);
    chk(relocValid && relocBlock == 4'd14, "R11 requeue after full", relocBlock, 14);
    drain("R11 drain");

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule